// File: doc/BRIEF.md
# Byte-wide SPI master peripheral

A register-mapped SPI master with an 8-bit host bus. Software programs a control byte (enable, master, clock polarity, clock phase, bit order, interrupt enable), a baud byte that sets the SCK rate, and a port byte whose bit 3 drives the active-low slave-select pin. Each write to the data register while the controller is enabled as master launches one 8-bit full-duplex exchange on SCK, MOSI and MISO. When the exchange ends, the received byte is readable at the data register and a done flag is raised.

Status flags use a two-step clear: software reads the status register and then reads the data register. A second data write while bits are still shifting does not disturb the exchange; it raises a collision flag so software can retry. If the slave-select pin is not configured as an output and an external device pulls it low while the block is an enabled master, the block raises a fault flag, drops out of master mode and aborts the exchange. The host bus has single-cycle strobes with combinational read data and no back-pressure: every access completes in the cycle it is presented.

Top module: `spi_byte_master`

## Requirements
- R1: After reset: control 0x00, baud 0x00, status 0x00, port 0x08, direction 0x00, SCK low, both interrupts low, ss_n_out high, ss_n_oe low.
- R2: Register offsets: control 0x00, reserved 0x01 (reads 0x00, writes ignored), baud 0x04, status 0x05, data 0x09, port 0x0D, direction 0x10. Control bits: 7 interrupt enable, 6 enable, 4 master, 3 polarity, 2 phase, 1 select-output enable, 0 LSB-first; bit 5 reads 0. Baud bits 7 and 3 read 0.
- R3: A data write while enable and master are set and no exchange runs loads the byte on that clock edge and shifts 8 bits out on MOSI while taking 8 bits from MISO; the received byte is then read at offset 0x09.
- R4: SCK idles at the polarity bit. With phase 0 the first bit is on MOSI before the first SCK edge and MISO is sampled on odd-numbered (leading) edges; with phase 1 MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: With bit 0 of control set, both directions move the least significant bit first; otherwise the most significant bit goes first.
- R6: Baud bits 6:4 hold P and bits 2:0 hold S; each SCK half period lasts (P+1)·2^S bus clocks, a full SCK period (P+1)·2^(S+1).
- R7: Status bit 7 sets when an exchange ends. Flags are cleared only by a status read that sees them set followed by a data read; a data read without the prior status read clears nothing.
- R8: A data write during an exchange sets status bit 6, starts no exchange and leaves the running exchange and its result unchanged; it clears the same way as bit 7.
- R9: While enable and master are set, if neither direction bit 3 nor control bit 1 is set and ss_n_in is low after a two-stage synchronizer, status bit 4 sets, control bits 6 and 4 clear, any exchange aborts and SCK returns to its idle level; later data writes start nothing.
- R10: irq_done is high exactly while control bit 7 and status bit 7 are both set; irq_fault is high exactly while control bit 7 and status bit 4 are both set.
- R11: ss_n_out follows port bit 3; ss_n_oe is high when direction bit 3 or control bit 1 is set.
- R12: A data write while enable or master is clear starts no exchange and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n_in | input | 1 | Slave-select pin level, used for fault detection |
| ss_n_out | output | 1 | Slave-select drive value |
| ss_n_oe | output | 1 | Slave-select output enable |
| irq_done | output | 1 | Exchange-complete interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |

## Verification
Exchanges run in all four polarity/phase combinations and both bit orders, with transmit and slave bytes chosen asymmetric so a swapped order, an off-by-one sample edge or a wrong idle level each corrupts a different byte. A behavioural slave captures MOSI and drives MISO per the selected mode, and the edge spacing it measures at several baud settings separates prescaler and shift errors. Flag handling is tried with the proper status-then-data clear, with a data read alone, with a write collision in a slow exchange and with a fault asserted mid-exchange, each followed by a register read that shows which flags survived.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RSVD  = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_BAUD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h09;
  localparam logic [ADDR_W-1:0] OFS_PORT  = 5'h0D;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h10;

  localparam int SEL_BIT = 3;
  localparam logic [BYTE_W-1:0] PORT_RST = 8'h08;

  // control byte, bit 7 down to bit 0
  typedef struct packed {
    logic ie;
    logic en;
    logic rsv;
    logic mst;
    logic pol;
    logic pha;
    logic sso;
    logic lsb;
  } ctrl_t;

  typedef struct packed {
    logic done;
    logic coll;
    logic fault;
  } flags_t;

endpackage

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
  import spi_bm_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int SHF_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ss_n_in,
  output ctrl_t             ctrl,
  output logic [PRE_W-1:0]  pre,
  output logic [SHF_W-1:0]  shf,
  output logic              start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              ss_n_out,
  output logic              ss_n_oe,
  output flags_t            flags,
  output logic              fault_evt
);

  logic [BYTE_W-1:0]      port_q, dir_q, rx_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ss_sync;
  logic                   armed_q;
  flags_t                 arm_mask_q, set_v, clr_v;
  logic                   wr_ctrl, wr_baud, wr_data, wr_port, wr_dir;
  logic                   rd_stat, rd_data, sel_is_out;

  assign wr_ctrl = wr && (addr == OFS_CTRL);
  assign wr_baud = wr && (addr == OFS_BAUD);
  assign wr_data = wr && (addr == OFS_DATA);
  assign wr_port = wr && (addr == OFS_PORT);
  assign wr_dir  = wr && (addr == OFS_DIR);
  assign rd_stat = rd && (addr == OFS_STAT);
  assign rd_data = rd && (addr == OFS_DATA);

  // pin synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ss_n_in};
  end
  assign ss_sync = sync_q[SYNC_STAGES-1];

  assign sel_is_out = dir_q[SEL_BIT] | ctrl.sso;
  assign fault_evt  = ctrl.en & ctrl.mst & ~sel_is_out & ~ss_sync;
  assign start      = wr_data & ctrl.en & ctrl.mst & ~busy & ~fault_evt;
  assign tx_byte    = wdata;
  assign ss_n_out   = port_q[SEL_BIT];
  assign ss_n_oe    = sel_is_out;

  // control, baud and port registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      pre    <= '0;
      shf    <= '0;
      port_q <= PORT_RST;
      dir_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl     <= ctrl_t'(wdata);
        ctrl.rsv <= 1'b0;
      end
      if (fault_evt) begin
        ctrl.en  <= 1'b0;
        ctrl.mst <= 1'b0;
      end
      if (wr_baud) begin
        pre <= wdata[4 +: PRE_W];
        shf <= wdata[0 +: SHF_W];
      end
      if (wr_port) port_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  // flag set / two-step clear
  always_comb begin
    set_v.done  = done;
    set_v.coll  = wr_data & busy;
    set_v.fault = fault_evt;
    clr_v       = (rd_data && armed_q) ? arm_mask_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags      <= '0;
      armed_q    <= 1'b0;
      arm_mask_q <= '0;
      rx_q       <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (rd_stat) begin
        armed_q    <= |flags;
        arm_mask_q <= flags;
      end else if (rd_data) begin
        armed_q <= 1'b0;
      end
      if (done) rx_q <= rx_byte;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CTRL: rdata = ctrl;
      OFS_BAUD: begin
        rdata[4 +: PRE_W] = pre;
        rdata[0 +: SHF_W] = shf;
      end
      OFS_STAT: rdata = {flags.done, flags.coll, 1'b0, flags.fault, 4'b0000};
      OFS_DATA: rdata = rx_q;
      OFS_PORT: rdata = port_q;
      OFS_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_bm_baud.sv
module spi_bm_baud #(
  parameter int PRE_W = 3,
  parameter int SHF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [SHF_W-1:0] shf,
  output logic             tick
);

  localparam int CNT_W = PRE_W + (1 << SHF_W);

  logic [CNT_W-1:0] cnt_q, half;

  assign half = ({{(CNT_W-PRE_W){1'b0}}, pre} + CNT_W'(1)) << shf;
  assign tick = run && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run||tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] tx,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            lsb,
  input  logic            abort,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            sck,
  output logic            mosi,
  output logic            done,
  output logic [BITS-1:0] rx
);

  localparam int EDGES = 2 * BITS;
  localparam int IDX_W = $clog2(EDGES);

  logic [IDX_W-1:0] idx_q;
  logic [BITS-1:0]  tx_sr, rx_sr, tx_ord, rx_next, rx_fin, rx_out;
  logic             sample, shift, last;

  // bit-order adapters
  always_comb begin
    for (int i = 0; i < BITS; i++) begin
      tx_ord[i] = lsb ? tx[BITS-1-i] : tx[i];
      rx_out[i] = lsb ? rx_fin[BITS-1-i] : rx_fin[i];
    end
  end

  assign sample  = (idx_q[0] == cpha);
  assign last    = (idx_q == IDX_W'(EDGES-1));
  assign shift   = (idx_q[0] != cpha) && !last;
  assign rx_next = {rx_sr[BITS-2:0], miso};
  assign rx_fin  = sample ? rx_next : rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sck   <= 1'b0;
      mosi  <= 1'b0;
      done  <= 1'b0;
      idx_q <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      rx    <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        sck  <= cpol;
      end else if (start) begin
        busy  <= 1'b1;
        idx_q <= '0;
        sck   <= cpol;
        if (!cpha) begin
          mosi  <= tx_ord[BITS-1];
          tx_sr <= tx_ord << 1;
        end else begin
          tx_sr <= tx_ord;
        end
      end else if (busy && tick) begin
        sck <= ~sck;
        if (sample) rx_sr <= rx_next;
        if (shift) begin
          mosi  <= tx_sr[BITS-1];
          tx_sr <= tx_sr << 1;
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          rx   <= rx_out;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end else if (!busy) begin
        sck <= cpol;
      end
    end
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int SHF_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              ss_n_in,
  output logic              ss_n_out,
  output logic              ss_n_oe,
  output logic              irq_done,
  output logic              irq_fault
);

  ctrl_t             ctrl_q;
  flags_t            flags_q;
  logic [PRE_W-1:0]  pre_q;
  logic [SHF_W-1:0]  shf_q;
  logic              xfer_start, eng_busy, eng_done, half_tick, fault_evt;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  spi_bm_regs #(
    .PRE_W(PRE_W), .SHF_W(SHF_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata), .rdata(bus_rdata),
    .busy(eng_busy), .done(eng_done), .rx_byte(rx_byte), .ss_n_in(ss_n_in),
    .ctrl(ctrl_q), .pre(pre_q), .shf(shf_q), .start(xfer_start), .tx_byte(tx_byte),
    .ss_n_out(ss_n_out), .ss_n_oe(ss_n_oe), .flags(flags_q), .fault_evt(fault_evt)
  );

  spi_bm_baud #(.PRE_W(PRE_W), .SHF_W(SHF_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .pre(pre_q), .shf(shf_q), .tick(half_tick)
  );

  spi_bm_shifter #(.BITS(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .tx(tx_byte),
    .cpol(ctrl_q.pol), .cpha(ctrl_q.pha), .lsb(ctrl_q.lsb),
    .abort(fault_evt), .tick(half_tick), .miso(miso),
    .busy(eng_busy), .sck(sck), .mosi(mosi), .done(eng_done), .rx(rx_byte)
  );

  assign irq_done  = ctrl_q.ie & flags_q.done;
  assign irq_fault = ctrl_q.ie & flags_q.fault;

endmodule

// File: rtl/spi_bm_chk.sv
module spi_bm_chk
  import spi_bm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              busy,
  input logic              start,
  input logic              sck,
  input ctrl_t             ctrl,
  input flags_t            flags,
  input logic              fault_evt
);

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(ctrl.pol)) |-> (sck == ctrl.pol));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !flags.coll));

  // R8
  coll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DATA && busy) |=> flags.coll);

  // R9
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!ctrl.en && !ctrl.mst && !busy && flags.fault));

  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !flags.fault) |=> flags.done);

endmodule

bind spi_byte_master spi_bm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .busy(eng_busy), .start(xfer_start), .sck(sck), .ctrl(ctrl_q),
  .flags(flags_q), .fault_evt(fault_evt)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sck, mosi, miso = 1'b0, ss_n_in = 1'b1;
  logic       ss_n_out, ss_n_oe, irq_done, irq_fault;

  always #10 clk = ~clk;

  spi_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .ss_n_in(ss_n_in), .ss_n_out(ss_n_out), .ss_n_oe(ss_n_oe),
    .irq_done(irq_done), .irq_fault(irq_fault)
  );

  int checks = 0, errors = 0;
  bit done_flag = 0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] rev8(logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  // behavioural slave
  bit         m_cpha = 0, m_lsb = 0;
  logic [7:0] sl_byte = '0, cap = '0;
  int         edge_n = 0, cyc = 0, t_e0 = 0, t_e1 = 0;
  logic       sck_prev = 1'b0;

  function automatic logic sl_bit(int j);
    return m_lsb ? sl_byte[j] : sl_byte[7-j];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (sck !== sck_prev) begin
      if (edge_n == 0) t_e0 = cyc;
      if (edge_n == 1) t_e1 = cyc;
      if ((edge_n % 2) == int'(m_cpha)) cap = {cap[6:0], mosi};
      if ((edge_n % 2) != int'(m_cpha) && edge_n != 15)
        miso = sl_bit(m_cpha ? edge_n / 2 : (edge_n + 1) / 2);
      edge_n++;
    end
    sck_prev = sck;
  end

  // scoreboard
  typedef struct { logic [7:0] rx; logic [7:0] cap; string req; } item_t;
  item_t exp_q[$], act_q[$];

  always begin
    wait (act_q.size() > 0);
    begin
      item_t a, e;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      chk({e.req, " rx byte"}, a.rx, e.rx);
      chk({e.req, " mosi byte"}, a.cap, e.cap);
    end
  end

  task automatic launch(logic [7:0] ctl, logic [7:0] tx, logic [7:0] sl);
    bwr(5'h00, ctl);
    repeat (3) @(negedge clk);
    m_cpha = ctl[2]; m_lsb = ctl[0]; sl_byte = sl; cap = '0; edge_n = 0;
    if (!m_cpha) miso = sl_bit(0);
    bwr(5'h09, tx);
  endtask

  task automatic wait_edges();
    for (int g = 0; g < 5000 && edge_n < 16; g++) @(negedge clk);
  endtask

  task automatic xfer(string req, logic [7:0] ctl, logic [7:0] tx, logic [7:0] sl);
    logic [7:0] st, d;
    item_t e, a;
    e.rx = sl; e.cap = tx; e.req = req;
    exp_q.push_back(e);
    launch(ctl, tx, sl);
    wait_edges();
    st = 8'h00;
    for (int g = 0; g < 50 && !st[7]; g++) brd(5'h05, st);
    chk({req, " R7 status after exchange"}, st, 8'h80);
    brd(5'h09, d);
    a.rx = d; a.cap = ctl[0] ? rev8(cap) : cap; a.req = req;
    act_q.push_back(a);
    brd(5'h05, st);
    chk({req, " R7 status cleared"}, st, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    brd(5'h00, v); chk("R1 ctrl", v, 8'h00);
    brd(5'h04, v); chk("R1 baud", v, 8'h00);
    brd(5'h05, v); chk("R1 status", v, 8'h00);
    brd(5'h0D, v); chk("R1 port", v, 8'h08);
    brd(5'h10, v); chk("R1 dir", v, 8'h00);
    chk("R1 pins", {3'b0, sck, ss_n_out, ss_n_oe, irq_done, irq_fault}, 8'h08);
    // R2
    bwr(5'h04, 8'hFF); brd(5'h04, v); chk("R2 baud mask", v, 8'h77);
    bwr(5'h01, 8'hFF); brd(5'h01, v); chk("R2 reserved", v, 8'h00);
    bwr(5'h00, 8'h3F); brd(5'h00, v); chk("R2 ctrl bit5", v, 8'h1F);
    bwr(5'h00, 8'h00);
    // R11
    bwr(5'h10, 8'h0E); bwr(5'h0D, 8'h00);
    chk("R11 select pins", {6'b0, ss_n_out, ss_n_oe}, 8'h01);
    bwr(5'h04, 8'h00);
    // R3 R4 R5
    xfer("R3 mode0", 8'h50, 8'hA5, 8'h3C);
    xfer("R4 pha1", 8'h54, 8'h96, 8'h5A);
    xfer("R4 pol1", 8'h58, 8'h0F, 8'hF1);
    repeat (2) @(negedge clk);
    chk("R4 idle level pol1", {7'b0, sck}, 8'h01);
    xfer("R4 pol1 pha1", 8'h5C, 8'hC3, 8'h81);
    xfer("R5 lsb mode0", 8'h51, 8'h01, 8'h80);
    xfer("R5 lsb mode3", 8'h5D, 8'h2E, 8'h74);
    // R6
    bwr(5'h04, 8'h21);
    xfer("R6 baud21", 8'h50, 8'h6B, 8'hD2);
    chk("R6 half period 6", 8'(t_e1 - t_e0), 8'd6);
    bwr(5'h04, 8'h02);
    xfer("R6 baud02", 8'h54, 8'h19, 8'h27);
    chk("R6 half period 4", 8'(t_e1 - t_e0), 8'd4);
    // R7 data read alone clears nothing
    bwr(5'h04, 8'h00);
    launch(8'h50, 8'h11, 8'h22); wait_edges(); repeat (3) @(negedge clk);
    brd(5'h09, v); chk("R7 rx", v, 8'h22);
    brd(5'h05, v); chk("R7 no clear without status read", v, 8'h80);
    brd(5'h09, v); brd(5'h05, v); chk("R7 clear after sequence", v, 8'h00);
    // R10
    launch(8'hD0, 8'h33, 8'h44); wait_edges(); repeat (3) @(negedge clk);
    chk("R10 irq_done set", {7'b0, irq_done}, 8'h01);
    brd(5'h05, v); brd(5'h09, v);
    chk("R10 irq_done cleared", {7'b0, irq_done}, 8'h00);
    launch(8'h50, 8'h33, 8'h44); wait_edges(); repeat (3) @(negedge clk);
    chk("R10 irq_done masked", {7'b0, irq_done}, 8'h00);
    brd(5'h05, v); brd(5'h09, v);
    // R8
    bwr(5'h04, 8'h21);
    launch(8'h50, 8'h55, 8'hAA);
    repeat (10) @(negedge clk);
    bwr(5'h09, 8'hFF);
    wait_edges(); repeat (40) @(negedge clk);
    chk("R8 no second exchange", 8'(edge_n), 8'd16);
    chk("R8 mosi byte intact", cap, 8'h55);
    brd(5'h05, v); chk("R8 collision flag", v, 8'hC0);
    brd(5'h09, v); chk("R8 rx intact", v, 8'hAA);
    brd(5'h05, v); chk("R8 flags cleared", v, 8'h00);
    // R12
    bwr(5'h00, 8'h10); repeat (3) @(negedge clk); edge_n = 0;
    bwr(5'h09, 8'h5A); repeat (40) @(negedge clk);
    chk("R12 disabled no edges", 8'(edge_n), 8'd0);
    brd(5'h05, v); chk("R12 no flag", v, 8'h00);
    // R9
    bwr(5'h10, 8'h06);
    launch(8'hD8, 8'h77, 8'h88);
    repeat (30) @(negedge clk);
    ss_n_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 sck idle after abort", {7'b0, sck}, 8'h01);
    chk("R9 irq_fault", {7'b0, irq_fault}, 8'h01);
    brd(5'h00, v); chk("R9 ctrl en/mst cleared", v, 8'h88);
    ss_n_in = 1'b1;
    repeat (3) @(negedge clk);
    brd(5'h05, v); chk("R9 fault flag", v, 8'h10);
    brd(5'h09, v); brd(5'h05, v); chk("R9 fault cleared", v, 8'h00);
    e0 = edge_n;
    bwr(5'h09, 8'h3C); repeat (60) @(negedge clk);
    chk("R9 no exchange after fault", 8'(edge_n - e0), 8'd0);
    bwr(5'h10, 8'h0E);

    wait (act_q.size() == 0);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule